// File: doc/BRIEF.md
# Systolic Tile Wavefront Sequencer

This block runs one weight-stationary matrix-multiply job on an N×N grid of multiply-accumulate cells. After a start pulse it takes the N rows of the weight matrix, one row per cycle, and stores them in the grid. It then accepts the requested number of activation vectors over a ready/valid handshake. Each accepted vector enters a staircase of delay lines, so that lane k reaches the grid k cycles after lane 0. Partial sums fall down the columns. The bottom edge of the grid emits column j earlier than column j+1, so a second, mirrored staircase delays column j by N−1−j cycles. As a result, every result row leaves the block whole, on a single cycle.

The sequencer steps through five phases: idle, weight load, streaming, draining and done. It keeps count of rows accepted and rows emitted, and it counts the cycles the job has taken. During draining no activation is accepted, and zero activations enter the grid so that the last wavefront flushes out. The cycle count is held after the job ends, so the caller can compare it with the fill-and-drain cost.

Top module: `systolic_tile_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, busy, done, w_ready, act_ready and res_valid are 0 and job_cycles is 0.
- R2: A start pulse in the idle phase raises w_ready for exactly N consecutive cycles. In the i-th of those cycles (counting from 0), w_row is stored as weight row i. Field j, bits [j*DW +: DW], signed two's complement, is the weight of grid column j.
- R3: act_ready rises only after all N weight rows are stored, and it stays high until row_count rows have been accepted. A row is accepted in a cycle where act_valid and act_ready are both 1.
- R4: Each result row is the signed vector–matrix product of its activation row and the weight matrix. Activation lane k, bits [k*DW +: DW], multiplies weight row k. Result field j, bits [j*AW +: AW], is sum over k of x[k]*W[k][j], in signed two's complement.
- R5: A row accepted in cycle c is emitted with res_valid high in cycle c+2N−1, and all N fields are correct in that same cycle.
- R6: Results come out in the order their rows were accepted. Back-to-back input gives one result row per cycle, and exactly row_count rows are emitted per job.
- R7: An act_valid or act_row value has no effect while act_ready is low. A cycle with act_ready high and act_valid low inserts a gap and changes no result.
- R8: done is high for exactly one cycle, in the cycle after the last result row is emitted, with busy low. With no input gaps, job_cycles then reads 3N+M−1: N load cycles plus M+2N−1 streaming and draining cycles.
- R9: A job with row_count 0 loads the weights, emits no result, and raises done after N cycles with job_cycles equal to N.
- R10: A start pulse and a changed row_count while a job is running are ignored. The job emits the row count latched at its own start.
- R11: job_cycles counts every load, stream and drain cycle of a job (including gaps). It holds its value from done until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job when the block is idle |
| row_count | input | CW | Number of activation rows M, latched at start |
| w_ready | output | 1 | High during the N weight-load cycles |
| w_row | input | N*DW | Weight row for the current load cycle |
| act_valid | input | 1 | Activation row present |
| act_ready | output | 1 | Block takes activation rows |
| act_row | input | N*DW | Activation vector, lane k in bits [k*DW +: DW] |
| res_valid | output | 1 | A whole result row is on res_row |
| res_row | output | N*AW | Result vector, column j in bits [j*AW +: AW] |
| busy | output | 1 | Load, stream or drain phase |
| done | output | 1 | One-cycle end-of-job pulse |
| job_cycles | output | CYW | Cycles used by the current or last job |

## Verification
The hardest situation to reach is a wavefront with holes in it. The gated zeros from stalled cycles must travel through the input staircase and the grid next to real rows, and every real row must still come out intact, exactly 2N−1 cycles after its own acceptance. The bench creates this with a repeating stall mask on act_valid, and it drives act_valid high with junk data while act_ready is low. Each emitted row is compared against its own acceptance cycle, not against a fixed schedule. A second hard case is a start pulse with a larger row_count in mid-stream. The bench injects it during streaming and checks that the row count and the cycle total stay those of the original job.

// File: rtl/systolic_tile_pkg.sv
package systolic_tile_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LOADW  = 3'd1,
    PH_STREAM = 3'd2,
    PH_DRAIN  = 3'd3,
    PH_DONE   = 3'd4
  } tile_phase_e;

  // Delay applied to a lane of a triangular delay network.
  // Ascending: lane k waits k cycles. Mirrored: lane k waits LANES-1-k.
  function automatic int lane_delay(input int lane, input int lanes, input bit mirrored);
    return mirrored ? (lanes - 1 - lane) : lane;
  endfunction

  // Cycles from the acceptance of a row to its whole result row on the ports.
  function automatic int result_latency(input int n);
    return 2 * n - 1;
  endfunction

  // Index width that stays at least one bit for a single-entry range.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/systolic_tile_pe.sv
module systolic_tile_pe #(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 w_load,
  input  logic signed [DW-1:0] w_in,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [AW-1:0] p_in,
  output logic signed [AW-1:0] p_out
);
  localparam int PW = 2 * DW;

  logic signed [DW-1:0] w_q;

  // Sign-extended product added to the partial sum falling in from above.
  function automatic logic signed [AW-1:0] mac_step(
    input logic signed [AW-1:0] psum,
    input logic signed [DW-1:0] act,
    input logic signed [DW-1:0] wgt
  );
    logic signed [PW-1:0] prod;
    prod = act * wgt;
    return psum + AW'(prod);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      p_out <= '0;
    end else begin
      if (w_load) w_q <= w_in;
      p_out <= mac_step(p_in, a_in, w_q);
    end
  end

endmodule

// File: rtl/systolic_tile_tri_delay.sv
module systolic_tile_tri_delay
  import systolic_tile_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int W        = 8,
  parameter bit MIRRORED = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES*W-1:0] din,
  output logic [LANES*W-1:0] dout
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int D = lane_delay(k, LANES, MIRRORED);
    if (D == 0) begin : g_pass
      assign dout[k*W +: W] = din[k*W +: W];
    end else begin : g_pipe
      logic [W-1:0] stage [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < D; i++) stage[i] <= '0;
        end else begin
          stage[0] <= din[k*W +: W];
          for (int i = 1; i < D; i++) stage[i] <= stage[i-1];
        end
      end
      assign dout[k*W +: W] = stage[D-1];
    end
  end

endmodule

// File: rtl/systolic_tile_array.sv
module systolic_tile_array #(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int LDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_en,
  input  logic [LDW-1:0]  w_sel,
  input  logic [N*DW-1:0] w_row,
  input  logic [N*DW-1:0] a_lanes,
  output logic [N*AW-1:0] p_bottom
);
  // a_h[i][j]: activation seen by cell (i,j); p_v[i][j]: partial sum entering cell (i,j)
  logic signed [DW-1:0] a_h [N][N];
  logic signed [AW-1:0] p_v [N+1][N];

  for (genvar j = 0; j < N; j++) begin : g_edge
    assign p_v[0][j]            = '0;
    assign p_bottom[j*AW +: AW] = p_v[N][j];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    assign a_h[i][0] = a_lanes[i*DW +: DW];
    for (genvar j = 0; j < N; j++) begin : g_col
      systolic_tile_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk    (clk),
        .rst_n  (rst_n),
        .w_load (w_en && (w_sel == LDW'(i))),
        .w_in   (w_row[j*DW +: DW]),
        .a_in   (a_h[i][j]),
        .p_in   (p_v[i][j]),
        .p_out  (p_v[i+1][j])
      );
      // one-cycle hop of the activation to the east neighbour
      if (j < N - 1) begin : g_hop
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) a_h[i][j+1] <= '0;
          else        a_h[i][j+1] <= a_h[i][j];
        end
      end
    end
  end

endmodule

// File: rtl/systolic_tile_seq.sv
module systolic_tile_seq
  import systolic_tile_pkg::*;
#(
  parameter int N   = 4,
  parameter int CW  = 8,
  parameter int CYW = 16,
  parameter int LDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  row_count,
  input  logic           act_valid,
  output logic           w_ready,
  output logic [LDW-1:0] w_sel,
  output logic           act_ready,
  output logic           accept,
  output logic           res_valid,
  output logic           busy,
  output logic           done,
  output logic           wts_loaded,
  output logic [CYW-1:0] job_cycles
);
  localparam int LAT = result_latency(N);

  tile_phase_e    phase_q, phase_d;
  logic [LDW-1:0] ld_q;
  logic [CW-1:0]  m_q, acc_q, emit_q;
  logic [LAT-1:0] tag_q;
  logic [CYW-1:0] cyc_q;

  // named phase events
  logic job_go, load_last, stream_last, drain_last;

  assign w_ready   = (phase_q == PH_LOADW);
  assign act_ready = (phase_q == PH_STREAM);
  assign busy      = (phase_q == PH_LOADW) || (phase_q == PH_STREAM) || (phase_q == PH_DRAIN);
  assign done      = (phase_q == PH_DONE);
  assign accept    = act_valid && act_ready;
  assign res_valid = tag_q[LAT-1];
  assign w_sel     = ld_q;
  assign job_cycles = cyc_q;

  assign job_go      = (phase_q == PH_IDLE) && start;
  assign load_last   = w_ready && (ld_q == LDW'(N - 1));
  assign stream_last = accept && (acc_q == m_q - CW'(1));
  assign drain_last  = (phase_q == PH_DRAIN) && res_valid && (emit_q == m_q - CW'(1));

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (job_go) phase_d = PH_LOADW;
      PH_LOADW:  if (load_last) phase_d = (m_q == '0) ? PH_DONE : PH_STREAM;
      PH_STREAM: if (stream_last) phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_last) phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      ld_q       <= '0;
      m_q        <= '0;
      acc_q      <= '0;
      emit_q     <= '0;
      tag_q      <= '0;
      cyc_q      <= '0;
      wts_loaded <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tag_q   <= (tag_q << 1) | LAT'(accept);
      if (job_go) begin
        m_q        <= row_count;
        ld_q       <= '0;
        acc_q      <= '0;
        emit_q     <= '0;
        cyc_q      <= '0;
        wts_loaded <= 1'b0;
      end else begin
        if (busy)      cyc_q  <= cyc_q + CYW'(1);
        if (w_ready)   ld_q   <= ld_q + LDW'(1);
        if (load_last) wts_loaded <= 1'b1;
        if (accept)    acc_q  <= acc_q + CW'(1);
        if (res_valid) emit_q <= emit_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/systolic_tile_top.sv
module systolic_tile_top
  import systolic_tile_pkg::*;
#(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int AW  = 20,
  parameter int CW  = 8,
  parameter int CYW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   row_count,
  output logic            w_ready,
  input  logic [N*DW-1:0] w_row,
  input  logic            act_valid,
  output logic            act_ready,
  input  logic [N*DW-1:0] act_row,
  output logic            res_valid,
  output logic [N*AW-1:0] res_row,
  output logic            busy,
  output logic            done,
  output logic [CYW-1:0]  job_cycles
);
  localparam int LDW = idx_width(N);

  logic [LDW-1:0]  w_sel;
  logic            job_accept;
  logic            wts_loaded;
  logic [N*DW-1:0] a_gated;
  logic [N*DW-1:0] a_lanes;
  logic [N*AW-1:0] p_bottom;

  systolic_tile_seq #(.N(N), .CW(CW), .CYW(CYW), .LDW(LDW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .row_count  (row_count),
    .act_valid  (act_valid),
    .w_ready    (w_ready),
    .w_sel      (w_sel),
    .act_ready  (act_ready),
    .accept     (job_accept),
    .res_valid  (res_valid),
    .busy       (busy),
    .done       (done),
    .wts_loaded (wts_loaded),
    .job_cycles (job_cycles)
  );

  // Non-accepted cycles push a zero wavefront so the grid flushes cleanly.
  assign a_gated = job_accept ? act_row : '0;

  systolic_tile_tri_delay #(.LANES(N), .W(DW), .MIRRORED(1'b0)) u_skew (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (a_gated),
    .dout  (a_lanes)
  );

  systolic_tile_array #(.N(N), .DW(DW), .AW(AW), .LDW(LDW)) u_grid (
    .clk      (clk),
    .rst_n    (rst_n),
    .w_en     (w_ready),
    .w_sel    (w_sel),
    .w_row    (w_row),
    .a_lanes  (a_lanes),
    .p_bottom (p_bottom)
  );

  systolic_tile_tri_delay #(.LANES(N), .W(AW), .MIRRORED(1'b1)) u_deskew (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (p_bottom),
    .dout  (res_row)
  );

endmodule

// File: rtl/systolic_tile_chk.sv
module systolic_tile_chk #(
  parameter int N   = 4,
  parameter int CYW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           w_ready,
  input logic           act_ready,
  input logic           job_accept,
  input logic           res_valid,
  input logic           busy,
  input logic           done,
  input logic           wts_loaded,
  input logic [CYW-1:0] job_cycles
);
  localparam int LAT = 2 * N - 1;

  int inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 0;
    else        inflight <= inflight + (job_accept ? 1 : 0) - (res_valid ? 1 : 0);
  end

  // R3
  act_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_ready |-> wts_loaded);

  // R2
  load_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready |-> (busy && !act_ready && !res_valid));

  // R5
  result_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (inflight > 0));

  // R6
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= LAT);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !res_valid && !act_ready && inflight == 0));

  // R11
  cycles_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(job_cycles));

endmodule

bind systolic_tile_top systolic_tile_chk #(.N(N), .CYW(CYW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .w_ready    (w_ready),
  .act_ready  (act_ready),
  .job_accept (job_accept),
  .res_valid  (res_valid),
  .busy       (busy),
  .done       (done),
  .wts_loaded (wts_loaded),
  .job_cycles (job_cycles)
);

// File: tb/tb_systolic_tile_top.sv
module tb_systolic_tile_top;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int AW  = 20;
  localparam int CW  = 8;
  localparam int CYW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CW-1:0]   row_count = '0;
  logic            w_ready;
  logic [N*DW-1:0] w_row = '0;
  logic            act_valid = 1'b0;
  logic            act_ready;
  logic [N*DW-1:0] act_row = '0;
  logic            res_valid;
  logic [N*AW-1:0] res_row;
  logic            busy;
  logic            done;
  logic [CYW-1:0]  job_cycles;

  int checks = 0;
  int errors = 0;

  int wm [N][N];
  int xm [256][N];
  int acc_cyc [256];

  always #2 clk = ~clk;

  systolic_tile_top #(.N(N), .DW(DW), .AW(AW), .CW(CW), .CYW(CYW)) dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int seed, input int a, input int b);
    if (seed == 99) return -128;
    if (seed == 98) return 127;
    return ((seed * 37 + a * 11 + b * 29 + a * b * 3) % 256) - 128;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 res_valid in reset", res_valid, 0);
    chk("R1 ready flags in reset", {w_ready, act_ready, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 job_cycles after reset", job_cycles, 0);
  endtask

  // One job: m rows, stall_mask bit (cyc%8)=1 holds act_valid low,
  // restart_mid pulses start with a larger count during streaming.
  task automatic run_job(input int m, input int stall_mask, input int seed, input bit restart_mid);
    int wcnt = 0, sent = 0, got = 0, cyc = 0;
    bit finished = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wm[i][j] = pick(seed, i, j);
    for (int r = 0; r < m; r++)
      for (int k = 0; k < N; k++) xm[r][k] = pick(seed + 1, r, k);
    start = 1'b1;
    row_count = CW'(m);
    @(negedge clk);
    start = 1'b0;
    while (!finished && cyc < 2000) begin
      // sample outputs of this cycle
      if (res_valid) begin
        if (got >= m) chk("R6 extra result row", got, m - 1);
        else begin
          chk("R5 result latency", cyc, acc_cyc[got] + 2 * N - 1);
          for (int j = 0; j < N; j++) begin
            longint expv = 0;
            logic signed [AW-1:0] f;
            for (int k = 0; k < N; k++) expv += longint'(xm[got][k]) * longint'(wm[k][j]);
            f = res_row[j*AW +: AW];
            chk("R4 R6 result field", longint'(f), expv);
          end
        end
        got++;
      end
      if (w_ready) chk("R2 load cycle index", cyc, wcnt);
      if (act_ready && sent == 0) chk("R3 weights stored before stream", wcnt, N);
      if (done) begin
        chk("R8 rows emitted at done", got, m);
        chk("R8 busy low at done", busy, 0);
        chk("R11 job_cycles at done", job_cycles, cyc);
        if (stall_mask == 0 && m > 0) chk("R8 stall-free cycle total", job_cycles, 3 * N + m - 1);
        if (m == 0) chk("R9 empty job cycles", job_cycles, N);
        finished = 1;
      end
      // drive inputs for this cycle
      start = (restart_mid && cyc == N + 1);
      row_count = restart_mid ? CW'(m + 3) : CW'(m);
      if (w_ready) begin
        for (int j = 0; j < N; j++) w_row[j*DW +: DW] = DW'(wm[wcnt][j]);
        wcnt++;
      end else w_row = {N{8'h5A}};
      if (act_ready) begin
        if (sent < m && !stall_mask[cyc % 8]) begin
          act_valid = 1'b1;
          for (int k = 0; k < N; k++) act_row[k*DW +: DW] = DW'(xm[sent][k]);
          acc_cyc[sent] = cyc;
          sent++;
        end else begin
          act_valid = 1'b0;
          act_row = {N{8'h7E}};
        end
      end else begin
        // R7: junk offered while not ready must be ignored
        act_valid = cyc[0];
        act_row = {N{8'hA5}};
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    act_valid = 1'b0;
    if (!finished) chk("R8 job never finished", 0, 1);
    chk("R2 weight rows taken", wcnt, N);
    chk("R10 rows emitted equals latched count", got, m);
    begin
      logic [CYW-1:0] held;
      held = job_cycles;
      repeat (4) @(negedge clk);
      chk("R11 job_cycles held in idle", job_cycles, held);
      chk("R1 R8 idle after job", {busy, done, res_valid}, 0);
    end
  endtask

  task automatic t_single_row();   run_job(1, 0, 1, 1'b0);            endtask
  task automatic t_back_to_back(); run_job(12, 0, 2, 1'b0);           endtask
  task automatic t_stalls();       run_job(9, 8'b0110_0100, 3, 1'b0); endtask
  task automatic t_empty();        run_job(0, 0, 4, 1'b0);            endtask
  task automatic t_restart();      run_job(5, 0, 5, 1'b1);            endtask
  task automatic t_extreme_neg();  run_job(3, 0, 99, 1'b0);           endtask
  task automatic t_extreme_pos();  run_job(3, 8'b0000_0010, 98, 1'b0); endtask
  task automatic t_batch();        run_job(40, 0, 7, 1'b0);           endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_row();
    t_back_to_back();
    t_stalls();
    t_empty();
    t_restart();
    t_extreme_neg();
    t_extreme_pos();
    t_batch();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule